// File: doc/BRIEF.md
# ACPI Power Management Event Block

This block holds the fixed-feature power management registers of a chipset. A free-running timer advances once per pulse of a tick-enable input, which the clock generator pulses at 3.579545 MHz. A 16-bit event status register collects timer-overflow, global, power-button and RTC events. A 16-bit enable register selects which of those events drive the level-sensitive SCI interrupt output. A control register holds the SCI enable bit and a suspend-type field. It also decodes a suspend-enable strobe that is never stored and that, with suspend type zero, raises a one-cycle soft power-off request.

Software reaches the registers through a simple I/O bus. Writes are 16 bits wide, and reads return 32 bits so that the timer can be fetched whole. The register window is 64 bytes and sits at a base address whose low six bits are ignored. It answers only while a decode-enable input is high. A pair of APM byte ports at a fixed address completes the block. A command written there can switch ACPI mode on or off, and any command write can raise a one-cycle SMI request when a configuration input permits it.

Register offsets inside the window: event status 0x00, event enable 0x02, control 0x04, timer 0x08. Any other offset reads as zero.

Top module: `pmEventBlock`

## Requirements
- R1: The timer counter is TMR_WIDTH bits wide (default 24) and resets to 0. It increments by one on every clock edge where tickEn is high, holds while tickEn is low, and wraps silently to 0. A read at offset 0x08 returns the count zero-extended to 32 bits.
- R2: Status bit 0 (timer overflow) sets on the tick where counter bit TMR_WIDTH-1 changes value. This happens every 2^(TMR_WIDTH-1) ticks, including at the wrap.
- R3: Writing 1 to a status bit at positions 0, 5, 8 or 10 clears it, and writing 0 leaves it unchanged. Every other status bit reads 0. If an event sets a bit in the same cycle that a write clears it, the bit is left set.
- R4: A high level on evGlobal sets status bit 5, on evPwrBtn sets bit 8, and on evRtc sets bit 10. The bit is visible in the cycle after the input was sampled.
- R5: The enable register at offset 0x02 stores and reads back all 16 bits. sci is high exactly while (status AND enable) is non-zero in bits 10, 8, 5 or 0. Enable bits at other positions have no effect on sci.
- R6: The control register at offset 0x04 stores every written bit except bit 13, which always reads 0. Bit 0 is SCI enable and bits 12:10 are the suspend type.
- R7: A control write with bit 13 set and bits 12:10 equal to 0 makes shutdownReq high for exactly one cycle, in the cycle after the write. A control write with any other suspend type produces no pulse.
- R8: A write of 0xF1 to the APM command port (APM_PORT, default 0x00B2) sets control bit 0, and a write of 0xF0 clears it. Any other value leaves the bit unchanged. The command port and the status port (APM_PORT+1) each read back the last byte written to them.
- R9: Every write to the APM command port while smiEnable is high makes smiReq high for one cycle, in the cycle after the write. With smiEnable low no pulse occurs.
- R10: The window decodes the 64 bytes from ioBase with its bits 5:0 treated as zero. When decodeEn is low, or when the address lies outside the window, writes are ignored and reads return 0. The APM ports decode regardless of decodeEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioBase | input | 16 | Register window base (bits 5:0 ignored) |
| decodeEn | input | 1 | Window decode enable |
| ioAddr | input | 16 | Bus byte address |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioWdata | input | 16 | Write data |
| ioRdata | output | 32 | Read data for ioAddr (combinational) |
| tickEn | input | 1 | Timer tick enable |
| evGlobal | input | 1 | Global event |
| evPwrBtn | input | 1 | Power-button event |
| evRtc | input | 1 | RTC alarm event |
| smiEnable | input | 1 | Allows SMI on APM command writes |
| sci | output | 1 | Level-sensitive SCI |
| shutdownReq | output | 1 | One-cycle soft power-off request |
| smiReq | output | 1 | One-cycle SMI request |

## Verification
The SCI function is exercised with single events, with two events at once, and with enable masks that cover only unrelated bit positions, only the other pending event, or exactly the pending one. These cases separate a correct AND-then-mask from a plain OR of status bits and from a mask that ignores position. The timer is run in short bursts to intermediate counts, across the half-range boundary and through the wrap. These show whether overflow detection reacts to a bit change, not only to a rising bit, and that clearing the bit does not disturb counting. The control and APM writes pair the strobe with zero and non-zero suspend types, and ACPI codes with an unrelated byte, so that decoding of each field is told apart.

// File: rtl/pmEvtPkg.sv
package pmEvtPkg;

  localparam int REG_W = 16;
  localparam int RD_W  = 32;
  localparam int OFF_W = 6;

  // event bit positions shared by status and enable registers
  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

  // control register fields
  localparam int CTL_SCI_BIT = 0;
  localparam int CTL_STB_BIT = 13;
  localparam int CTL_TYP_LO  = 10;

  // register window offsets
  localparam logic [OFF_W-1:0] OFF_STS = 6'h00;
  localparam logic [OFF_W-1:0] OFF_EN  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TMR = 6'h08;

  localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
  localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

  typedef enum logic [2:0] {
    RD_NONE, RD_STS, RD_EN, RD_CTL, RD_TMR, RD_APMC, RD_APMS
  } rdSel_e;

  typedef struct packed {
    logic   wrSts;
    logic   wrEn;
    logic   wrCtl;
    logic   wrApmCmd;
    logic   wrApmSts;
    logic   sciOn;
    logic   sciOff;
    rdSel_e rdSel;
  } pmStrobes_t;

endpackage

// File: rtl/pmCtrl.sv
module pmCtrl
  import pmEvtPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] APM_PORT = ADDR_W'(16'h00B2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioBase,
  input  logic              decodeEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic [3:0]        susBits,   // {strobe, type[2:0]} of write data
  input  logic [7:0]        apmByte,
  input  logic              smiEnable,
  output pmStrobes_t        strb,
  output logic              shutdownReq,
  output logic              smiReq
);

  localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'((1 << OFF_W) - 1);
  localparam logic [ADDR_W-1:0] APM_STS_PORT = APM_PORT + ADDR_W'(1);

  logic             winHit;
  logic             apmCmdHit;
  logic             apmStsHit;
  logic [OFF_W-1:0] offset;

  assign winHit    = decodeEn && (((ioAddr ^ ioBase) & WIN_MASK) == '0);
  assign apmCmdHit = (ioAddr == APM_PORT);
  assign apmStsHit = (ioAddr == APM_STS_PORT);
  assign offset    = ioAddr[OFF_W-1:0];

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (apmCmdHit) begin
      strb.rdSel    = RD_APMC;
      strb.wrApmCmd = ioWr;
      strb.sciOn    = ioWr && (apmByte == APM_ACPI_ON);
      strb.sciOff   = ioWr && (apmByte == APM_ACPI_OFF);
    end else if (apmStsHit) begin
      strb.rdSel    = RD_APMS;
      strb.wrApmSts = ioWr;
    end else if (winHit) begin
      unique case (offset)
        OFF_STS: begin strb.rdSel = RD_STS; strb.wrSts = ioWr; end
        OFF_EN:  begin strb.rdSel = RD_EN;  strb.wrEn  = ioWr; end
        OFF_CTL: begin strb.rdSel = RD_CTL; strb.wrCtl = ioWr; end
        OFF_TMR: strb.rdSel = RD_TMR;
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdownReq <= 1'b0;
      smiReq      <= 1'b0;
    end else begin
      shutdownReq <= strb.wrCtl && (susBits == 4'b1000);
      smiReq      <= strb.wrApmCmd && smiEnable;
    end
  end

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(strb.wrCtl) && ($past(susBits) == 4'b1000)); // R7
  AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> $past(smiEnable) && $past(apmCmdHit) && $past(ioWr)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSts, strb.wrEn, strb.wrCtl, strb.wrApmCmd, strb.wrApmSts})); // R10

endmodule

// File: rtl/pmData.sv
module pmData
  import pmEvtPkg::*;
#(
  parameter int TMR_WIDTH = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmStrobes_t       strb,
  input  logic [REG_W-1:0] wdata,
  input  logic             tickEn,
  input  logic             evGlobal,
  input  logic             evPwrBtn,
  input  logic             evRtc,
  output logic [RD_W-1:0]  rdata,
  output logic             sci
);

  localparam int TOP = TMR_WIDTH - 1;
  localparam logic [REG_W-1:0] STB_CLR = ~REG_W'(1 << CTL_STB_BIT);

  logic [TMR_WIDTH-1:0] tmrCount;
  logic [TMR_WIDTH-1:0] tmrInc;
  logic                 ovfEdge;
  logic [REG_W-1:0]     stsReg, stsNext, evSet;
  logic [REG_W-1:0]     enReg;
  logic [REG_W-1:0]     ctlReg;
  logic [7:0]           apmCmd, apmSts;

  // free-running timer
  assign tmrInc  = tmrCount + TMR_WIDTH'(1);
  assign ovfEdge = tickEn && (tmrInc[TOP] != tmrCount[TOP]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       tmrCount <= '0;
    else if (tickEn) tmrCount <= tmrInc;
  end

  // event status: clear by write-one, then apply new events (set wins)
  always_comb begin
    evSet          = '0;
    evSet[BIT_TMR] = ovfEdge;
    evSet[BIT_GBL] = evGlobal;
    evSet[BIT_PWR] = evPwrBtn;
    evSet[BIT_RTC] = evRtc;
    stsNext = stsReg;
    if (strb.wrSts) stsNext = stsNext & ~(wdata & EVT_MASK);
    stsNext = stsNext | evSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsReg <= '0;
    else       stsReg <= stsNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enReg <= '0;
    else if (strb.wrEn) enReg <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctlReg <= '0;
    else if (strb.wrCtl)   ctlReg <= wdata & STB_CLR;
    else if (strb.sciOn)   ctlReg[CTL_SCI_BIT] <= 1'b1;
    else if (strb.sciOff)  ctlReg[CTL_SCI_BIT] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      apmCmd <= '0;
      apmSts <= '0;
    end else begin
      if (strb.wrApmCmd) apmCmd <= wdata[7:0];
      if (strb.wrApmSts) apmSts <= wdata[7:0];
    end
  end

  assign sci = |(stsReg & enReg & EVT_MASK);

  always_comb begin
    unique case (strb.rdSel)
      RD_STS:  rdata = RD_W'(stsReg);
      RD_EN:   rdata = RD_W'(enReg);
      RD_CTL:  rdata = RD_W'(ctlReg);
      RD_TMR:  rdata = RD_W'(tmrCount);
      RD_APMC: rdata = RD_W'(apmCmd);
      RD_APMS: rdata = RD_W'(apmSts);
      default: rdata = '0;
    endcase
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> tmrCount == $past(tmrCount) + TMR_WIDTH'(1)); // R1
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tmrCount)); // R1
  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsReg[BIT_TMR]) |-> $past(tickEn)
      && (tmrCount[TOP] != $past(tmrCount[TOP]))); // R2
  AST_STS_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    (stsReg & ~EVT_MASK) == '0); // R3
  AST_ACPI_ON: assert property (@(posedge clk) disable iff (!rstN)
    strb.sciOn |=> ctlReg[CTL_SCI_BIT]); // R8
  AST_ACPI_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strb.sciOff |=> !ctlReg[CTL_SCI_BIT]); // R8
  AST_STB_NOT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[CTL_STB_BIT]); // R6

endmodule

// File: rtl/pmEventBlock.sv
module pmEventBlock
  import pmEvtPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TMR_WIDTH = 24,
  parameter logic [ADDR_W-1:0] APM_PORT = ADDR_W'(16'h00B2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioBase,
  input  logic              decodeEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic [REG_W-1:0]  ioWdata,
  output logic [RD_W-1:0]   ioRdata,
  input  logic              tickEn,
  input  logic              evGlobal,
  input  logic              evPwrBtn,
  input  logic              evRtc,
  input  logic              smiEnable,
  output logic              sci,
  output logic              shutdownReq,
  output logic              smiReq
);

  pmStrobes_t strb;

  pmCtrl #(.ADDR_W(ADDR_W), .APM_PORT(APM_PORT)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ioBase     (ioBase),
    .decodeEn   (decodeEn),
    .ioAddr     (ioAddr),
    .ioWr       (ioWr),
    .susBits    (ioWdata[CTL_STB_BIT:CTL_TYP_LO]),
    .apmByte    (ioWdata[7:0]),
    .smiEnable  (smiEnable),
    .strb       (strb),
    .shutdownReq(shutdownReq),
    .smiReq     (smiReq)
  );

  pmData #(.TMR_WIDTH(TMR_WIDTH)) data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (ioWdata),
    .tickEn  (tickEn),
    .evGlobal(evGlobal),
    .evPwrBtn(evPwrBtn),
    .evRtc   (evRtc),
    .rdata   (ioRdata),
    .sci     (sci)
  );

endmodule

// File: tb/pmEventBlock_test.sv
module pmEventBlock_test;

  localparam int TW = 10;  // short timer: overflow every 512 ticks, wrap at 1024

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioBase = 16'h1237;  // window base resolves to 0x1200
  logic        decodeEn = 1'b1;
  logic [15:0] ioAddr = 16'h0;
  logic        ioWr = 1'b0;
  logic [15:0] ioWdata = 16'h0;
  logic [31:0] ioRdata;
  logic        tickEn = 1'b0;
  logic        evGlobal = 1'b0, evPwrBtn = 1'b0, evRtc = 1'b0;
  logic        smiEnable = 1'b0;
  logic        sci, shutdownReq, smiReq;

  int checks = 0;
  int fails = 0;
  int shutCount = 0;
  int smiCount = 0;

  always #10 clk = ~clk;

  pmEventBlock #(.TMR_WIDTH(TW)) uut (
    .clk(clk), .rstN(rstN), .ioBase(ioBase), .decodeEn(decodeEn),
    .ioAddr(ioAddr), .ioWr(ioWr), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .tickEn(tickEn), .evGlobal(evGlobal), .evPwrBtn(evPwrBtn), .evRtc(evRtc),
    .smiEnable(smiEnable), .sci(sci), .shutdownReq(shutdownReq), .smiReq(smiReq)
  );

  always @(posedge clk) begin
    if (rstN && shutdownReq) shutCount++;
    if (rstN && smiReq) smiCount++;
  end

  localparam logic [15:0] A_STS = 16'h1200, A_EN = 16'h1202, A_CTL = 16'h1204;
  localparam logic [15:0] A_TMR = 16'h1208, A_APMC = 16'h00B2, A_APMS = 16'h00B3;

  // {req[3:0], write, addr[15:0], data[31:0]}; for reads data is the expected value
  localparam int NV = 19;
  localparam logic [52:0] VEC [NV] = '{
    {4'd5,  1'b1, A_EN,   32'h0000_0521},  // R5 enable write
    {4'd5,  1'b0, A_EN,   32'h0000_0521},  // R5 readback
    {4'd6,  1'b1, A_CTL,  32'h0000_1C01},  // R6 type 7, SCI enable
    {4'd6,  1'b0, A_CTL,  32'h0000_1C01},  // R6
    {4'd6,  1'b1, A_CTL,  32'h0000_2C01},  // R6 strobe with type 3
    {4'd6,  1'b0, A_CTL,  32'h0000_0C01},  // R6 strobe not kept
    {4'd8,  1'b1, A_APMC, 32'h0000_00F0},  // R8 ACPI off
    {4'd8,  1'b0, A_CTL,  32'h0000_0C00},  // R8
    {4'd8,  1'b1, A_APMC, 32'h0000_00F1},  // R8 ACPI on
    {4'd8,  1'b0, A_CTL,  32'h0000_0C01},  // R8
    {4'd8,  1'b1, A_APMC, 32'h0000_0055},  // R8 other code
    {4'd8,  1'b0, A_CTL,  32'h0000_0C01},  // R8 unchanged
    {4'd8,  1'b0, A_APMC, 32'h0000_0055},  // R8 command readback
    {4'd8,  1'b1, A_APMS, 32'h0000_003C},  // R8 status port
    {4'd8,  1'b0, A_APMS, 32'h0000_003C},  // R8
    {4'd3,  1'b0, A_STS,  32'h0000_0000},  // R3 nothing pending
    {4'd3,  1'b1, A_STS,  32'h0000_FFFF},  // R3 clear all
    {4'd3,  1'b0, A_STS,  32'h0000_0000},  // R3 unused bits read 0
    {4'd10, 1'b0, 16'h1206, 32'h0000_0000} // R10 unmapped offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    ioAddr = a;
    #2 d = ioRdata;
  endtask

  task automatic sampleSci(output logic s);
    @(negedge clk);
    #2 s = sci;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic s;
    repeat (3) @(negedge clk);
    // reset state
    check("R3 reset status", {31'd0, sci}, 32'd0);
    rd(A_STS, v); check("R3 reset status", v, 32'h0);
    rd(A_TMR, v); check("R1 reset timer", v, 32'h0);
    rstN = 1'b1;
    rd(A_EN, v);  check("R5 reset enable", v, 32'h0);
    rd(A_CTL, v); check("R6 reset control", v, 32'h0);
    check("R7 reset shutdown", {31'd0, shutdownReq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][47:32], VEC[i][15:0]);
      else begin
        rd(VEC[i][47:32], v);
        check($sformatf("R%0d vector %0d", VEC[i][52:49], i), v, VEC[i][31:0]);
      end
    end
    repeat (2) @(negedge clk);
    check("R7 strobe with type 3 gives no pulse", shutCount, 0);
    check("R9 no SMI while disabled", smiCount, 0);

    // R4/R5 events and SCI
    @(negedge clk); evPwrBtn = 1'b1; @(negedge clk); evPwrBtn = 1'b0;
    rd(A_STS, v); check("R4 power button bit 8", v, 32'h0100);
    sampleSci(s); check("R5 sci on enabled event", {31'd0, s}, 32'd1);
    wr(A_STS, 16'h0000);
    rd(A_STS, v); check("R3 write zero no effect", v, 32'h0100);
    wr(A_STS, 16'h0100);
    rd(A_STS, v); check("R3 write one clears", v, 32'h0);
    sampleSci(s); check("R5 sci drops", {31'd0, s}, 32'd0);
    wr(A_EN, 16'h0000);
    @(negedge clk); evRtc = 1'b1; evGlobal = 1'b1; @(negedge clk); evRtc = 1'b0; evGlobal = 1'b0;
    rd(A_STS, v); check("R4 rtc and global bits", v, 32'h0420);
    sampleSci(s); check("R5 sci masked by enable", {31'd0, s}, 32'd0);
    wr(A_EN, 16'hFBDF);
    sampleSci(s); check("R5 unrelated enables no sci", {31'd0, s}, 32'd0);
    wr(A_EN, 16'h0020);
    sampleSci(s); check("R5 sci from global", {31'd0, s}, 32'd1);
    wr(A_STS, 16'h0420);
    rd(A_STS, v); check("R3 two bits cleared", v, 32'h0);

    // R1/R2 timer
    wr(A_EN, 16'h0001);
    ticks(300);
    rd(A_TMR, v); check("R1 timer count", v, 32'd300);
    ticks(211);
    rd(A_STS, v); check("R2 no overflow below boundary", v, 32'h0);
    ticks(1);
    rd(A_TMR, v); check("R1 timer at boundary", v, 32'd512);
    rd(A_STS, v); check("R2 overflow at boundary", v, 32'h0001);
    sampleSci(s); check("R5 sci from overflow", {31'd0, s}, 32'd1);
    wr(A_STS, 16'h0001);
    rd(A_STS, v); check("R2 overflow cleared", v, 32'h0);
    repeat (10) @(negedge clk);
    rd(A_TMR, v); check("R1 timer holds without tick", v, 32'd512);
    ticks(512);
    rd(A_TMR, v); check("R1 timer wraps", v, 32'd0);
    rd(A_STS, v); check("R2 overflow at wrap", v, 32'h0001);
    wr(A_STS, 16'h0001);

    // R7 soft power off
    wr(A_CTL, 16'h2001);
    repeat (2) @(negedge clk);
    check("R7 one shutdown pulse", shutCount, 1);
    rd(A_CTL, v); check("R6 strobe reads zero", v, 32'h0001);
    wr(A_CTL, 16'h2401);
    repeat (2) @(negedge clk);
    check("R7 type 1 no pulse", shutCount, 1);

    // R9 SMI
    smiEnable = 1'b1;
    wr(A_APMC, 16'h0012);
    repeat (2) @(negedge clk);
    check("R9 one SMI pulse", smiCount, 1);
    rd(A_CTL, v); check("R8 other code keeps SCI enable", v, 32'h0401);
    smiEnable = 1'b0;
    wr(A_APMC, 16'h0034);
    repeat (2) @(negedge clk);
    check("R9 no SMI when disabled", smiCount, 1);

    // R10 decode
    decodeEn = 1'b0;
    wr(A_EN, 16'hAAAA);
    rd(A_EN, v); check("R10 read zero when decode off", v, 32'h0);
    wr(A_APMS, 16'h0077);
    rd(A_APMS, v); check("R10 APM decoded regardless", v, 32'h0077);
    decodeEn = 1'b1;
    rd(A_EN, v); check("R10 write ignored when decode off", v, 32'h0001);
    wr(16'h1242, 16'h5555);
    rd(A_EN, v); check("R10 outside window ignored", v, 32'h0001);
    rd(16'h1242, v); check("R10 outside window reads zero", v, 32'h0);

    finishRun();
  end

endmodule